// File: doc/BRIEF.md
# Miss Acquire Issue Arbiter

This block chooses which outstanding cache-miss entry goes next onto the request (A) channel toward the next-level cache, and builds the acquire message for it. Two pools of miss entries feed it. Each pool supplies one "pending and not yet issued" flag and one line address per entry. Demand-fetch entries always win. The lowest-indexed pending demand entry goes first. Prefetch entries go strictly in the order they were allocated. An internal FIFO of prefetch entry indices, written at allocation time, tracks that order.

A new acquire is loaded only while the response side reports the bus idle. Once presented, the acquire stays unchanged until the handshake completes. In the handshake cycle the block pulses an issue strobe to the chosen entry, so its pool can mark the entry as issued. A prefetch flush empties the order FIFO.

Top module: `miss_issue_arb`

## Requirements
- R1: After reset `acq_valid_o` is low and every bit of `dem_issue_o` and `pf_issue_o` is low.
- R2: No acquire is loaded in a cycle where `bus_idle_i` is low; loading resumes once it is high.
- R3: When any demand entry is pending at selection time, a demand entry is chosen even if a prefetch is ready.
- R4: Among pending demand entries the lowest index is chosen.
- R5: Prefetch entries are chosen in allocation order, whatever their indices.
- R6: The acquire carries opcode 3'd6, transaction ID equal to the entry ID (demand entry i has ID i, prefetch entry j has ID N_DEM+j), and that entry's line address.
- R7: While `acq_valid_o` is high and `acq_ready_i` low, valid, ID, opcode and address stay unchanged, even if the pending flags change.
- R8: In the handshake cycle exactly one issue strobe is high, the one for the entry named by `acq_id_o`; in any other cycle no strobe is high.
- R9: Only the FIFO head prefetch may be issued. If the head is not yet pending, no prefetch is issued, even when later ones are pending. The head is removed when it is issued.
- R10: `pf_flush_i` empties the order FIFO, and an allocation in the same cycle is dropped. A prefetch acquire already presented still completes unchanged.
- R11: An acquire appears one cycle after a cycle in which the bus is idle, no acquire is presented and a candidate exists. A prefetch allocated in cycle t becomes a candidate in cycle t+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_idle_i | input | 1 | Response side idle; a new acquire may be loaded |
| dem_pend_i | input | N_DEM | Demand entries pending and not yet issued |
| dem_addr_i | input | N_DEM*LINE_ADDR_W | Demand entry line addresses, entry i at bits i*LINE_ADDR_W upward |
| pf_pend_i | input | N_PF | Prefetch entries pending and not yet issued |
| pf_addr_i | input | N_PF*LINE_ADDR_W | Prefetch entry line addresses, packed like `dem_addr_i` |
| pf_alloc_i | input | 1 | A prefetch entry is allocated this cycle |
| pf_alloc_idx_i | input | PF_IW | Index of the allocated prefetch entry |
| pf_flush_i | input | 1 | Invalidate all prefetch entries; clears the order FIFO |
| acq_valid_o | output | 1 | Acquire valid |
| acq_ready_i | input | 1 | Acquire accepted by the channel |
| acq_opcode_o | output | 3 | Acquire opcode |
| acq_id_o | output | ID_W | Transaction ID, equal to the entry ID |
| acq_addr_o | output | LINE_ADDR_W | Line address |
| dem_issue_o | output | N_DEM | One-cycle issue strobe per demand entry |
| pf_issue_o | output | N_PF | One-cycle issue strobe per prefetch entry |

## Verification
A demand candidate shows up on the channel one edge after the bus-idle and pending conditions first hold. A prefetch needs two edges from its allocation: one to enter the FIFO and one to load. The bench drives inputs on the falling edge and samples on the next falling edge(s) at exactly those counts. Issue strobes are combinational on the handshake, so they are sampled in the same low phase in which ready is raised. The valid drop and the FIFO pop are checked one falling edge later. Where nothing should happen (idle gating, a head that is not pending, a flushed FIFO), the bench holds the stimulus for several cycles and checks that valid stays low throughout.

// File: rtl/miss_arb_pkg.sv
package miss_arb_pkg;
  typedef enum logic [2:0] {
    A_OP_GET       = 3'd4,
    A_OP_ACQ_BLOCK = 3'd6,
    A_OP_ACQ_PERM  = 3'd7
  } a_op_e;
endpackage

// File: rtl/dem_prio_pick.sv
module dem_prio_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          vld_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
  assign vld_o = |req_i;
endmodule

// File: rtl/pf_order_fifo.sv
module pf_order_fifo #(
  parameter int DEPTH = 10,
  parameter int W     = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_i,
  output logic         empty_o,
  output logic [W-1:0] head_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign empty_o = (cnt_q == '0);
  assign head_o  = mem_q[rd_q];
  assign do_push = push_i && !flush_i && (cnt_q != CW'(DEPTH));
  assign do_pop  = pop_i && !flush_i && !empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (do_push) begin
      mem_q[wr_q] <= push_data_i;
    end
  end
endmodule

// File: rtl/miss_issue_arb.sv
module miss_issue_arb
  import miss_arb_pkg::*;
#(
  parameter int N_DEM       = 4,
  parameter int N_PF        = 10,
  parameter int LINE_ADDR_W = 26,
  localparam int ID_W  = $clog2(N_DEM + N_PF),
  localparam int DEM_IW = (N_DEM > 1) ? $clog2(N_DEM) : 1,
  localparam int PF_IW = (N_PF > 1) ? $clog2(N_PF) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         bus_idle_i,
  input  logic [N_DEM-1:0]             dem_pend_i,
  input  logic [N_DEM*LINE_ADDR_W-1:0] dem_addr_i,
  input  logic [N_PF-1:0]              pf_pend_i,
  input  logic [N_PF*LINE_ADDR_W-1:0]  pf_addr_i,
  input  logic                         pf_alloc_i,
  input  logic [PF_IW-1:0]             pf_alloc_idx_i,
  input  logic                         pf_flush_i,
  output logic                         acq_valid_o,
  input  logic                         acq_ready_i,
  output logic [2:0]                   acq_opcode_o,
  output logic [ID_W-1:0]              acq_id_o,
  output logic [LINE_ADDR_W-1:0]       acq_addr_o,
  output logic [N_DEM-1:0]             dem_issue_o,
  output logic [N_PF-1:0]              pf_issue_o
);
  logic              dem_any;
  logic [DEM_IW-1:0] dem_idx;
  logic              fifo_empty;
  logic [PF_IW-1:0]  pf_head;
  logic              pf_ready, sel_vld, load, hs, pop;
  logic [ID_W-1:0]   sel_id;
  logic [LINE_ADDR_W-1:0] sel_addr;

  logic                   valid_q, is_pf_q;
  logic [ID_W-1:0]        id_q;
  logic [LINE_ADDR_W-1:0] addr_q;

  dem_prio_pick #(.N(N_DEM)) u_dem_pick (
    .req_i (dem_pend_i),
    .vld_o (dem_any),
    .idx_o (dem_idx)
  );

  pf_order_fifo #(.DEPTH(N_PF), .W(PF_IW)) u_pf_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (pf_flush_i),
    .push_i      (pf_alloc_i),
    .push_data_i (pf_alloc_idx_i),
    .pop_i       (pop),
    .empty_o     (fifo_empty),
    .head_o      (pf_head)
  );

  // strict allocation order: only the head may go
  assign pf_ready = !fifo_empty && pf_pend_i[pf_head];
  assign sel_vld  = dem_any || pf_ready;

  always_comb begin
    if (dem_any) begin
      sel_id   = ID_W'(dem_idx);
      sel_addr = dem_addr_i[int'(dem_idx)*LINE_ADDR_W +: LINE_ADDR_W];
    end else begin
      sel_id   = ID_W'(N_DEM) + ID_W'(pf_head);
      sel_addr = pf_addr_i[int'(pf_head)*LINE_ADDR_W +: LINE_ADDR_W];
    end
  end

  assign load = !valid_q && bus_idle_i && sel_vld;
  assign hs   = valid_q && acq_ready_i;
  assign pop  = hs && is_pf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      is_pf_q <= 1'b0;
      id_q    <= '0;
      addr_q  <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      is_pf_q <= !dem_any;
      id_q    <= sel_id;
      addr_q  <= sel_addr;
    end else if (hs) begin
      valid_q <= 1'b0;
    end
  end

  assign acq_valid_o  = valid_q;
  assign acq_opcode_o = A_OP_ACQ_BLOCK;
  assign acq_id_o     = id_q;
  assign acq_addr_o   = addr_q;

  for (genvar gi = 0; gi < N_DEM; gi++) begin : g_dem_iss
    assign dem_issue_o[gi] = hs && (id_q == ID_W'(gi));
  end
  for (genvar gj = 0; gj < N_PF; gj++) begin : g_pf_iss
    assign pf_issue_o[gj] = hs && (id_q == ID_W'(N_DEM + gj));
  end
endmodule

// File: rtl/miss_issue_arb_chk.sv
module miss_issue_arb_chk #(
  parameter int N_DEM       = 4,
  parameter int N_PF        = 10,
  parameter int LINE_ADDR_W = 26,
  localparam int ID_W = $clog2(N_DEM + N_PF)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   bus_idle_i,
  input logic [N_DEM-1:0]       dem_pend_i,
  input logic                   acq_valid_o,
  input logic                   acq_ready_i,
  input logic [2:0]             acq_opcode_o,
  input logic [ID_W-1:0]        acq_id_o,
  input logic [LINE_ADDR_W-1:0] acq_addr_o,
  input logic [N_DEM-1:0]       dem_issue_o,
  input logic [N_PF-1:0]        pf_issue_o
);
  logic [N_DEM-1:0] low_mask;
  logic             is_dem;
  always_comb low_mask = (N_DEM'(1) << acq_id_o) - N_DEM'(1);
  assign is_dem = acq_id_o < ID_W'(N_DEM);

  AST_IDLE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(acq_valid_o) |-> $past(bus_idle_i)); // R2

  AST_DEM_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(acq_valid_o) && $past(|dem_pend_i) |-> is_dem); // R3

  AST_DEM_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(acq_valid_o) && is_dem |-> ($past(dem_pend_i) & low_mask) == '0); // R4

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acq_valid_o && !acq_ready_i |=> acq_valid_o && $stable(acq_id_o)
      && $stable(acq_addr_o) && $stable(acq_opcode_o)); // R7

  AST_ISSUE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acq_valid_o && acq_ready_i |-> $countones({pf_issue_o, dem_issue_o}) == 1); // R8

  AST_ISSUE_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acq_valid_o && acq_ready_i) |-> {pf_issue_o, dem_issue_o} == '0); // R8
endmodule

bind miss_issue_arb miss_issue_arb_chk #(
  .N_DEM(N_DEM), .N_PF(N_PF), .LINE_ADDR_W(LINE_ADDR_W)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_idle_i   (bus_idle_i),
  .dem_pend_i   (dem_pend_i),
  .acq_valid_o  (acq_valid_o),
  .acq_ready_i  (acq_ready_i),
  .acq_opcode_o (acq_opcode_o),
  .acq_id_o     (acq_id_o),
  .acq_addr_o   (acq_addr_o),
  .dem_issue_o  (dem_issue_o),
  .pf_issue_o   (pf_issue_o)
);

// File: tb/miss_issue_arb_tb_top.sv
module miss_issue_arb_tb_top;
  localparam int N_DEM = 4;
  localparam int N_PF  = 10;
  localparam int AW    = 26;
  localparam int ID_W  = $clog2(N_DEM + N_PF);
  localparam int PF_IW = $clog2(N_PF);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_idle = 1'b0;
  logic [N_DEM-1:0] dem_pend = '0;
  logic [N_DEM*AW-1:0] dem_addr;
  logic [N_PF-1:0] pf_pend = '0;
  logic [N_PF*AW-1:0] pf_addr;
  logic pf_alloc = 1'b0;
  logic [PF_IW-1:0] pf_alloc_idx = '0;
  logic pf_flush = 1'b0;
  logic acq_ready = 1'b0;
  logic acq_valid;
  logic [2:0] acq_opcode;
  logic [ID_W-1:0] acq_id;
  logic [AW-1:0] acq_addr;
  logic [N_DEM-1:0] dem_issue;
  logic [N_PF-1:0] pf_issue;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #4 clk = ~clk;

  for (genvar i = 0; i < N_DEM; i++) begin : g_da
    assign dem_addr[i*AW +: AW] = AW'(32'h100 + i);
  end
  for (genvar j = 0; j < N_PF; j++) begin : g_pa
    assign pf_addr[j*AW +: AW] = AW'(32'h200 + j);
  end

  miss_issue_arb #(.N_DEM(N_DEM), .N_PF(N_PF), .LINE_ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_idle_i(bus_idle),
    .dem_pend_i(dem_pend), .dem_addr_i(dem_addr),
    .pf_pend_i(pf_pend), .pf_addr_i(pf_addr),
    .pf_alloc_i(pf_alloc), .pf_alloc_idx_i(pf_alloc_idx), .pf_flush_i(pf_flush),
    .acq_valid_o(acq_valid), .acq_ready_i(acq_ready), .acq_opcode_o(acq_opcode),
    .acq_id_o(acq_id), .acq_addr_o(acq_addr),
    .dem_issue_o(dem_issue), .pf_issue_o(pf_issue)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_addr(input int id);
    return (id < N_DEM) ? AW'(32'h100 + id) : AW'(32'h200 + id - N_DEM);
  endfunction

  // wait for an acquire, check it, complete handshake, retire entry like a pool would
  task automatic take_acq(input int exp_id, input string tag);
    int n = 0;
    while (!acq_valid && n < 20) begin @(negedge clk); n++; end
    chk(acq_valid, {tag, " valid"}, acq_valid, 1);
    chk(acq_id == ID_W'(exp_id), {tag, " R6 id"}, acq_id, exp_id);
    chk(acq_addr == exp_addr(exp_id), {tag, " R6 addr"}, acq_addr, exp_addr(exp_id));
    chk(acq_opcode == 3'd6, {tag, " R6 opcode"}, acq_opcode, 6);
    acq_ready = 1'b1;
    #1;
    chk({pf_issue, dem_issue} == ((N_DEM + N_PF)'(1) << exp_id), {tag, " R8 issue"},
        {pf_issue, dem_issue}, (N_DEM + N_PF)'(1) << exp_id);
    @(negedge clk);
    acq_ready = 1'b0;
    if (exp_id < N_DEM) dem_pend[exp_id] = 1'b0;
    else pf_pend[exp_id - N_DEM] = 1'b0;
    chk(!acq_valid, {tag, " R8 drop"}, acq_valid, 0);
    chk({pf_issue, dem_issue} == '0, {tag, " R8 no strobe"}, {pf_issue, dem_issue}, 0);
  endtask

  task automatic alloc(input int idx, input bit pend);
    pf_alloc = 1'b1;
    pf_alloc_idx = PF_IW'(idx);
    if (pend) pf_pend[idx] = 1'b1;
    @(negedge clk);
    pf_alloc = 1'b0;
  endtask

  task automatic quiet(input int cycles, input string tag);
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      chk(!acq_valid, tag, acq_valid, 0);
    end
  endtask

  task automatic t_reset();
    chk(!acq_valid, "R1 valid", acq_valid, 0);
    chk({pf_issue, dem_issue} == '0, "R1 strobes", {pf_issue, dem_issue}, 0);
  endtask

  task automatic t_dem_lowest();
    bus_idle = 1'b1;
    dem_pend = 4'b1010;
    @(negedge clk);
    chk(acq_valid, "R11 dem latency", acq_valid, 1);
    take_acq(1, "R4 first");
    take_acq(3, "R4 second");
  endtask

  task automatic t_idle_gate();
    bus_idle = 1'b0;
    dem_pend = 4'b0001;
    quiet(5, "R2 idle low");
    bus_idle = 1'b1;
    @(negedge clk);
    chk(acq_valid, "R2 R11 resume", acq_valid, 1);
    take_acq(0, "R2 issue");
  endtask

  task automatic t_pf_order();
    alloc(7, 1'b1);
    chk(!acq_valid, "R11 pf not yet", acq_valid, 0);
    alloc(2, 1'b1);
    chk(acq_valid, "R11 pf latency", acq_valid, 1);
    alloc(5, 1'b1);
    take_acq(N_DEM + 7, "R5 first");
    take_acq(N_DEM + 2, "R5 second");
    take_acq(N_DEM + 5, "R5 third");
  endtask

  task automatic t_dem_first();
    bus_idle = 1'b0;
    alloc(3, 1'b1);
    dem_pend = 4'b0100;
    @(negedge clk);
    bus_idle = 1'b1;
    take_acq(2, "R3 demand");
    take_acq(N_DEM + 3, "R3 prefetch");
  endtask

  task automatic t_stable();
    dem_pend = 4'b0100;
    @(negedge clk);
    dem_pend[0] = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(acq_valid && acq_id == ID_W'(2), "R7 hold", acq_id, 2);
    end
    take_acq(2, "R7 release");
    take_acq(0, "R7 next");
  endtask

  task automatic t_head_wait();
    alloc(6, 1'b0);
    alloc(1, 1'b1);
    quiet(4, "R9 head not pending");
    pf_pend[6] = 1'b1;
    take_acq(N_DEM + 6, "R9 head");
    take_acq(N_DEM + 1, "R9 after head");
  endtask

  task automatic t_flush();
    bus_idle = 1'b0;
    alloc(8, 1'b1);
    alloc(9, 1'b1);
    pf_flush = 1'b1;
    alloc(0, 1'b1);
    pf_flush = 1'b0;
    pf_pend[8] = 1'b0;
    pf_pend[9] = 1'b0;
    bus_idle = 1'b1;
    quiet(5, "R10 flushed fifo");
    pf_pend[0] = 1'b0;
    alloc(4, 1'b1);
    @(negedge clk);
    chk(acq_valid && acq_id == ID_W'(N_DEM + 4), "R10 pf presented", acq_id, N_DEM + 4);
    pf_flush = 1'b1;
    @(negedge clk);
    pf_flush = 1'b0;
    chk(acq_valid && acq_id == ID_W'(N_DEM + 4), "R10 held across flush", acq_id, N_DEM + 4);
    take_acq(N_DEM + 4, "R10 complete");
    quiet(2, "R10 no stray");
    alloc(5, 1'b1);
    take_acq(N_DEM + 5, "R10 fifo reuse");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dem_lowest();
    t_idle_gate();
    t_pf_order();
    t_dem_first();
    t_stable();
    t_head_wait();
    t_flush();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule